// File: doc/BRIEF.md
# Immediate Shifter with Flag Generation

This block shifts a 32-bit source word by a 5-bit immediate amount. It offers three shift kinds: logical left, logical right and arithmetic right. With the result it returns the negative, zero and carry flags, each with a write-enable for the flag register that sits next to it. For right shifts an amount field of zero does not mean "no shift". It encodes a shift by the full word width, and the result and carry follow their own rules for that case. A left shift by zero leaves the word alone and passes the incoming carry straight through. The fourth op code is not valid. It raises an illegal indication, and every flag write-enable stays low.

Operands enter on a valid/ready channel, and results leave on a second one. The shift datapath is combinational. The parameter `REG_OUT` picks one of two output stages: a single pipeline register (the default), or a plain pass-through. With the register, a result appears one cycle after its operands are accepted. The result stays frozen while the consumer holds ready low, and new operands are accepted only when the register is empty or is being drained in that same cycle. The overflow flag is never touched, so its write-enable is tied low.

Top module: `imm_shift_unit`

## Requirements
- R1: `in_op` selects the shift kind: 2'b00 logical left, 2'b01 logical right, 2'b10 arithmetic right. For a nonzero amount n the result is the source shifted by n, with zeros filled in, except that an arithmetic right shift fills in copies of source bit 31.
- R2: For a nonzero amount n, the carry output is the last bit shifted out: source bit (32-n) for a left shift, and source bit (n-1) for either right shift.
- R3: A logical left shift with amount 0 returns the source unchanged, and the carry output equals `in_carry`.
- R4: A logical right shift with amount 0 acts as a shift by 32: the result is 0 and the carry output is source bit 31.
- R5: An arithmetic right shift with amount 0 acts as a shift by 32: every result bit equals source bit 31, and the carry output is source bit 31.
- R6: For a valid op, the negative flag is result bit 31, the zero flag is 1 exactly when the result is 0, and both `out_nz_we` and `out_c_we` are 1.
- R7: Op code 2'b11 sets `out_illegal` to 1, forces the result and the N, Z and C outputs to 0, and holds every write-enable at 0.
- R8: `out_v_we` is 0 for every result.
- R9: With `REG_OUT`=1: `in_ready` equals `!out_valid || out_ready`. Operands transfer on a cycle where `in_valid && in_ready`, and their result is presented at the next clock. A result held with `out_ready` low keeps `out_valid` high, and every output field stays stable.
- R10: While reset is asserted and after it is released, `out_valid` is 0 until the first transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand set is present |
| in_ready | output | 1 | Block accepts the operand set this cycle |
| in_op | input | 2 | Shift kind code |
| in_amt | input | 5 | Immediate shift amount (0 has special meaning, see R3 to R5) |
| in_src | input | 32 | Word to shift |
| in_carry | input | 1 | Current carry flag |
| out_valid | output | 1 | Result is present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_result | output | 32 | Shifted word |
| out_n | output | 1 | New negative flag |
| out_z | output | 1 | New zero flag |
| out_c | output | 1 | New carry flag |
| out_nz_we | output | 1 | Write-enable for N and Z |
| out_c_we | output | 1 | Write-enable for C |
| out_v_we | output | 1 | Write-enable for V, always 0 |
| out_illegal | output | 1 | Op code was not valid |

## Verification
The in-line assertions check, on every cycle, that a stalled result holds its value and its valid, that an illegal result never carries a flag write-enable, and that the N and Z outputs agree with the result word beside them. Whether the word and the carry are correct for each shift kind can only be judged by the bench's reference model. This includes the zero-amount cases, where right shifts mean a shift by 32, and the left shift by zero that passes the carry through. The bench compares against that model on every clock while driving directed corner vectors and random operand streams with random back-pressure.

// File: rtl/imm_shift_pkg.sv
package imm_shift_pkg;
  typedef enum logic [1:0] {
    SH_LSL = 2'b00,
    SH_LSR = 2'b01,
    SH_ASR = 2'b10,
    SH_BAD = 2'b11
  } shift_op_e;
endpackage

// File: rtl/imm_shift_core.sv
module imm_shift_core
  import imm_shift_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int AMT_W  = $clog2(DATA_W)
) (
  input  shift_op_e           op,
  input  logic [AMT_W-1:0]    amt,
  input  logic [DATA_W-1:0]   src,
  input  logic                cin,
  output logic [DATA_W-1:0]   res,
  output logic                cout,
  output logic                illegal
);
  localparam int EXT_W = DATA_W + 1;

  logic [EXT_W-1:0]        ext_left;
  logic [EXT_W-1:0]        ext_right;
  logic signed [EXT_W-1:0] ext_arith;
  logic                    amt_zero;
  logic                    msb;

  // One spare bit beside the word catches the last bit shifted out.
  assign ext_left  = {1'b0, src} << amt;
  assign ext_right = {src, 1'b0} >> amt;
  assign ext_arith = $signed({src, 1'b0}) >>> amt;
  assign amt_zero  = (amt == '0);
  assign msb       = src[DATA_W-1];

  always_comb begin
    res     = '0;
    cout    = 1'b0;
    illegal = 1'b0;
    unique case (op)
      SH_LSL: begin
        if (amt_zero) begin
          res  = src;
          cout = cin;
        end else begin
          res  = ext_left[DATA_W-1:0];
          cout = ext_left[DATA_W];
        end
      end
      SH_LSR: begin
        if (amt_zero) begin
          res  = '0;
          cout = msb;
        end else begin
          res  = ext_right[DATA_W:1];
          cout = ext_right[0];
        end
      end
      SH_ASR: begin
        if (amt_zero) begin
          res  = {DATA_W{msb}};
          cout = msb;
        end else begin
          res  = ext_arith[DATA_W:1];
          cout = ext_arith[0];
        end
      end
      default: begin
        illegal = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/imm_shift_flags.sv
module imm_shift_flags #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] res,
  input  logic              cin_shift,
  input  logic              illegal,
  output logic              flag_n,
  output logic              flag_z,
  output logic              flag_c,
  output logic              we_nz,
  output logic              we_c,
  output logic              we_v
);
  always_comb begin
    if (illegal) begin
      flag_n = 1'b0;
      flag_z = 1'b0;
      flag_c = 1'b0;
      we_nz  = 1'b0;
      we_c   = 1'b0;
    end else begin
      flag_n = res[DATA_W-1];
      flag_z = (res == '0);
      flag_c = cin_shift;
      we_nz  = 1'b1;
      we_c   = 1'b1;
    end
    we_v = 1'b0;
  end
endmodule

// File: rtl/imm_shift_stage.sv
module imm_shift_stage #(
  parameter int  PAY_W   = 39,
  parameter bit  REG_OUT = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             up_valid,
  output logic             up_ready,
  input  logic [PAY_W-1:0] up_data,
  output logic             dn_valid,
  input  logic             dn_ready,
  output logic [PAY_W-1:0] dn_data
);
  generate
    if (REG_OUT) begin : g_reg
      logic             full_q;
      logic [PAY_W-1:0] data_q;
      logic             take;

      assign up_ready = !full_q || dn_ready;
      assign take     = up_valid && up_ready;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          full_q <= 1'b0;
          data_q <= '0;
        end else begin
          if (take) begin
            full_q <= 1'b1;
            data_q <= up_data;
          end else if (dn_ready) begin
            full_q <= 1'b0;
          end
        end
      end

      assign dn_valid = full_q;
      assign dn_data  = data_q;

      a_r9_hold_valid: assert property (@(posedge clk) disable iff (!rst_n)
        dn_valid && !dn_ready |=> dn_valid);
      a_r9_hold_data: assert property (@(posedge clk) disable iff (!rst_n)
        dn_valid && !dn_ready |=> $stable(dn_data));
    end else begin : g_pass
      assign dn_valid = up_valid;
      assign up_ready = dn_ready;
      assign dn_data  = up_data;
    end
  endgenerate
endmodule

// File: rtl/imm_shift_unit.sv
module imm_shift_unit
  import imm_shift_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int AMT_W   = $clog2(DATA_W),
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [1:0]        in_op,
  input  logic [AMT_W-1:0]  in_amt,
  input  logic [DATA_W-1:0] in_src,
  input  logic              in_carry,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_result,
  output logic              out_n,
  output logic              out_z,
  output logic              out_c,
  output logic              out_nz_we,
  output logic              out_c_we,
  output logic              out_v_we,
  output logic              out_illegal
);
  localparam int FLAG_W = 7;
  localparam int PAY_W  = DATA_W + FLAG_W;

  logic [DATA_W-1:0] sh_res;
  logic              sh_cout;
  logic              sh_ill;
  logic              f_n, f_z, f_c, f_wnz, f_wc, f_wv;
  logic [PAY_W-1:0]  pay_in, pay_out;

  imm_shift_core #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_core (
    .op      (shift_op_e'(in_op)),
    .amt     (in_amt),
    .src     (in_src),
    .cin     (in_carry),
    .res     (sh_res),
    .cout    (sh_cout),
    .illegal (sh_ill)
  );

  imm_shift_flags #(.DATA_W(DATA_W)) u_flags (
    .res       (sh_res),
    .cin_shift (sh_cout),
    .illegal   (sh_ill),
    .flag_n    (f_n),
    .flag_z    (f_z),
    .flag_c    (f_c),
    .we_nz     (f_wnz),
    .we_c      (f_wc),
    .we_v      (f_wv)
  );

  assign pay_in = {sh_ill, f_wv, f_wc, f_wnz, f_c, f_z, f_n, sh_res};

  imm_shift_stage #(.PAY_W(PAY_W), .REG_OUT(REG_OUT)) u_stage (
    .clk      (clk),
    .rst_n    (rst_n),
    .up_valid (in_valid),
    .up_ready (in_ready),
    .up_data  (pay_in),
    .dn_valid (out_valid),
    .dn_ready (out_ready),
    .dn_data  (pay_out)
  );

  assign {out_illegal, out_v_we, out_c_we, out_nz_we,
          out_c, out_z, out_n, out_result} = pay_out;

  a_r7_illegal_no_we: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_illegal |-> !out_nz_we && !out_c_we && !out_v_we);
  a_r6_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_illegal |-> out_z == (out_result == '0));
  a_r6_neg_flag: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_illegal |-> out_n == out_result[DATA_W-1]);
endmodule

// File: tb/imm_shift_unit_tb.sv
module imm_shift_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [1:0]  in_op = 2'b00;
  logic [4:0]  in_amt = 5'd0;
  logic [31:0] in_src = 32'd0;
  logic        in_carry = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [31:0] out_result;
  logic        out_n, out_z, out_c, out_nz_we, out_c_we, out_v_we, out_illegal;

  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;

  imm_shift_unit u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_amt(in_amt), .in_src(in_src), .in_carry(in_carry),
    .out_valid(out_valid), .out_ready(out_ready), .out_result(out_result),
    .out_n(out_n), .out_z(out_z), .out_c(out_c), .out_nz_we(out_nz_we),
    .out_c_we(out_c_we), .out_v_we(out_v_we), .out_illegal(out_illegal)
  );

  // Reference model state
  logic        m_valid = 1'b0;
  logic [31:0] m_res;
  logic        m_c, m_ill;
  string       m_rtag, m_ctag;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic ref_shift(input logic [1:0] op, input int n, input logic [31:0] s,
                           input logic ci, output logic [31:0] r, output logic c,
                           output logic ill, output string rtag, output string ctag);
    ill = 1'b0; r = '0; c = 1'b0; rtag = "R1"; ctag = "R2";
    case (op)
      2'b00: if (n == 0) begin r = s; c = ci; rtag = "R3"; ctag = "R3"; end
             else begin r = s << n; c = s[32-n]; end
      2'b01: if (n == 0) begin r = '0; c = s[31]; rtag = "R4"; ctag = "R4"; end
             else begin r = s >> n; c = s[n-1]; end
      2'b10: if (n == 0) begin r = {32{s[31]}}; c = s[31]; rtag = "R5"; ctag = "R5"; end
             else begin
               for (int i = 0; i < 32; i++) r[i] = (i + n < 32) ? s[i+n] : s[31];
               c = s[n-1];
             end
      default: begin ill = 1'b1; rtag = "R7"; ctag = "R7"; end
    endcase
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) m_valid = 1'b0;
    else begin
      logic rdy;
      rdy = !m_valid || out_ready;
      if (m_valid && out_ready) m_valid = 1'b0;
      if (in_valid && rdy) begin
        ref_shift(in_op, int'(in_amt), in_src, in_carry, m_res, m_c, m_ill, m_rtag, m_ctag);
        m_valid = 1'b1;
      end
    end
  end

  task automatic compare();
    logic en, ez;
    chk(out_valid == m_valid, "R9", "out_valid", 32'(out_valid), 32'(m_valid));
    chk(in_ready == (!m_valid || out_ready), "R9", "in_ready", 32'(in_ready),
        32'(!m_valid || out_ready));
    if (m_valid && out_valid) begin
      en = m_ill ? 1'b0 : m_res[31];
      ez = m_ill ? 1'b0 : (m_res == 0);
      chk(out_result == m_res, m_rtag, "result", out_result, m_res);
      chk(out_c == m_c, m_ctag, "carry", 32'(out_c), 32'(m_c));
      chk(out_n == en && out_z == ez, m_ill ? "R7" : "R6", "n/z",
          {30'd0, out_n, out_z}, {30'd0, en, ez});
      chk(out_nz_we == !m_ill && out_c_we == !m_ill, m_ill ? "R7" : "R6", "we",
          {30'd0, out_nz_we, out_c_we}, {30'd0, !m_ill, !m_ill});
      chk(out_illegal == m_ill, "R7", "illegal", 32'(out_illegal), 32'(m_ill));
      chk(out_v_we == 1'b0, "R8", "v_we", 32'(out_v_we), 32'd0);
    end
  endtask

  task automatic step(input logic v, input logic [1:0] op, input logic [4:0] amt,
                      input logic [31:0] s, input logic ci, input logic rd);
    @(negedge clk);
    compare();
    in_valid = v; in_op = op; in_amt = amt; in_src = s; in_carry = ci; out_ready = rd;
  endtask

  initial begin
    #(8 * 200000);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R10", "out_valid in reset", 32'(out_valid), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R10", "out_valid after reset", 32'(out_valid), 32'd0);
    // R3: left by zero keeps word and carry (both carry values)
    step(1, 2'b00, 5'd0, 32'h8000_0001, 1'b1, 1);
    step(1, 2'b00, 5'd0, 32'h0000_0000, 1'b0, 1);
    // R4: right by zero is shift by 32
    step(1, 2'b01, 5'd0, 32'h8765_4321, 1'b0, 1);
    step(1, 2'b01, 5'd0, 32'h7FFF_FFFF, 1'b1, 1);
    // R5: arithmetic by zero fills with sign
    step(1, 2'b10, 5'd0, 32'h8000_0000, 1'b0, 1);
    step(1, 2'b10, 5'd0, 32'h7000_0000, 1'b1, 1);
    // R1/R2 nonzero extremes
    step(1, 2'b00, 5'd1, 32'h8000_0000, 1'b0, 1);
    step(1, 2'b00, 5'd31, 32'h0000_0003, 1'b0, 1);
    step(1, 2'b01, 5'd1, 32'h0000_0001, 1'b0, 1);
    step(1, 2'b01, 5'd31, 32'hC000_0000, 1'b0, 1);
    step(1, 2'b10, 5'd4, 32'hF000_0018, 1'b0, 1);
    step(1, 2'b10, 5'd31, 32'h4000_0000, 1'b1, 1);
    // R7 illegal op
    step(1, 2'b11, 5'd3, 32'hFFFF_FFFF, 1'b1, 1);
    // R9 back-pressure: stall then release
    step(1, 2'b00, 5'd8, 32'h1234_5678, 1'b0, 0);
    step(1, 2'b01, 5'd8, 32'hAAAA_5555, 1'b0, 0);
    step(1, 2'b01, 5'd8, 32'hAAAA_5555, 1'b0, 0);
    step(1, 2'b01, 5'd8, 32'hAAAA_5555, 1'b0, 1);
    step(0, 2'b00, 5'd0, 32'h0, 1'b0, 1);
    step(0, 2'b00, 5'd0, 32'h0, 1'b0, 1);
    // Random streams with random stalls
    for (int k = 0; k < 3000; k++) begin
      logic [4:0] a;
      a = ($urandom_range(0, 3) == 0) ? 5'd0 : 5'($urandom);
      step(1'($urandom), 2'($urandom), a, $urandom, 1'($urandom),
           ($urandom_range(0, 3) != 0));
    end
    step(0, 2'b00, 5'd0, 32'h0, 1'b0, 1);
    step(0, 2'b00, 5'd0, 32'h0, 1'b0, 1);
    @(negedge clk);
    compare();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule